// File: doc/BRIEF.md
# Stop-Mode Wake-Up Recovery Controller

This block manages sleep and wake for a small microcontroller core. Software programs a byte-wide recovery control register that picks a wake source, the level that counts as active on it, whether a long reset-hold follows the wake, and whether the system clock tick is slowed by a further divide stage. A one-cycle stop strobe puts the block into stop mode. While stopped it watches the synchronized port pins, an auxiliary recovery input and a watchdog timeout. When a qualified event arrives it raises a wake pulse, holds the core's internal reset for a long or a one-cycle window, and then pulses a release indication.

The top bit of the register is a hardware flag that tells software whether the last start came out of stop mode (warm) or from a power-on or an active-mode watchdog reset (cold). The block also drives a clock-enable tick at the oscillator rate divided by two, or by thirty-two when the extra divide is on. A wake always clears that extra divide.

Top module: `stopWakeCtrl`

## Requirements
- R1: After `porN` goes low, `regRdData` reads 0x20 (long delay on, level low, source 000, extra divide off, flag cold), `stopped`, `coreRstHold`, `wakeReq` and `releaseDone` are 0.
- R2: A `stopEntry` pulse while running (and no watchdog in the same cycle) sets `stopped` and sets bit 7 of `regRdData` to 1. A write never changes bit 7: the other seven bits take `regWrData[6:0]`.
- R3: Bits [4:2] select the wake source: 010 = `p3Pins[1]`, 011 = `p3Pins[2]`, 100 = `p3Pins[3]`, 101 = `p2Pins[7]`, 110 = NOR of `p2Pins[3:0]`, 111 = NOR of `p2Pins[7:0]`. A pin outside the selected source never wakes the block.
- R4: Bit 6 is the wake level: 1 wakes on a high value of the selected source, 0 on a low value.
- R5: In the NOR sources a pin whose `p2DirOut` bit is 1 is treated as low, so only input pins decide the NOR result.
- R6: With bit 5 = 0 (fast wake) the qualified source must be active for 5 consecutive cycles after synchronization; a shorter burst is rejected and restarts the count. With bit 5 = 1 a single active cycle wakes.
- R7: A wake gives one `wakeReq` pulse, then `coreRstHold` stays 1 for `LONG_DELAY` cycles (bit 5 = 1) or for 1 cycle (bit 5 = 0), followed by one `releaseDone` pulse as the hold drops; `stopped` is 0 from the wake on.
- R8: `auxWake` high is ORed with the selected source and wakes the block even with source 000.
- R9: A `wdtTimeout` pulse in stop mode wakes at once and leaves bit 7 at 1; a `wdtTimeout` pulse outside stop mode clears bit 7 to 0.
- R10: Pin activity while not in stop mode gives no wake, and sources 000 and 001 never wake from pins at either level.
- R11: `sysTick` pulses once every 2 cycles when bit 0 is 0 and once every 32 cycles when bit 0 is 1; a wake clears bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data (bit 7 ignored) |
| regRdData | output | 8 | Register read value, bit 7 = warm flag |
| stopEntry | input | 1 | One-cycle request to enter stop mode |
| wdtTimeout | input | 1 | Watchdog timeout pulse |
| p2Pins | input | 8 | Port 2 pin values (asynchronous) |
| p2DirOut | input | 8 | Port 2 direction, 1 = output |
| p3Pins | input | 3 | Port 3 pins 1 to 3 (asynchronous) |
| auxWake | input | 1 | Second recovery source, active high |
| wakeReq | output | 1 | One-cycle wake pulse |
| coreRstHold | output | 1 | Internal core reset hold |
| releaseDone | output | 1 | One-cycle pulse when the hold ends |
| stopped | output | 1 | Block is in stop mode |
| sysTick | output | 1 | System clock enable tick |

## Verification
The hardest case is the fast-wake width filter: a burst must arrive after two synchronizer stages and be counted in the stop state only, so a burst of exactly four cycles must be rejected while five is accepted. The bench sets the pins to a non-matching idle value, waits for the synchronizer to settle, enters stop, and then holds the matching value for an exact number of falling edges before restoring idle. The NOR masking case is reached by marking one port 2 pin as an output that reads high, so only the masked NOR can wake.

// File: rtl/swkPkg.sv
package swkPkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_RSVD = 3'b001,
    SRC_P31  = 3'b010,
    SRC_P32  = 3'b011,
    SRC_P33  = 3'b100,
    SRC_P27  = 3'b101,
    SRC_NORL = 3'b110,
    SRC_NORA = 3'b111
  } wakeSrc_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_HOLD = 2'd2
  } swkState_t;

  typedef struct packed {
    logic setWarm;
    logic clrWarm;
    logic clrDiv;
  } swkStrobe_t;

  localparam logic [6:0] CTRL_RESET = 7'h20;
  localparam int BIT_DIV   = 0;
  localparam int BIT_LONG  = 5;
  localparam int BIT_LEVEL = 6;
endpackage

// File: rtl/swkSync.sv
module swkSync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/swkDatapath.sv
module swkDatapath
  import swkPkg::*;
#(
  parameter int DIV_BASE  = 2,
  parameter int DIV_EXTRA = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [6:0] regWrData,
  input  swkStrobe_t strobe,
  input  logic [7:0] p2Pins,
  input  logic [7:0] p2DirOut,
  input  logic [3:1] p3Pins,
  input  logic       auxWake,
  output logic [7:0] regRdData,
  output logic       fastMode,
  output logic       srcQual,
  output logic       sysTick
);
  localparam int SYNC_W = 8 + 3 + 1;
  localparam int DIV_MAX = DIV_BASE * DIV_EXTRA;
  localparam int DIV_W = $clog2(DIV_MAX);

  logic [6:0] ctrlReg;
  logic       warmFlag;
  logic [SYNC_W-1:0] syncOut;
  logic [7:0] p2Sync, p2Masked;
  logic [3:1] p3Sync;
  logic       auxSync;
  logic       srcLevel, srcValid;
  wakeSrc_t   srcSel;
  logic [DIV_W-1:0] divCnt, divLimit;

  swkSync #(.WIDTH(SYNC_W)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({auxWake, p3Pins, p2Pins}),
    .dout(syncOut)
  );

  assign p2Sync  = syncOut[7:0];
  assign p3Sync  = syncOut[10:8];
  assign auxSync = syncOut[11];

  // control register and hardware flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RESET;
      warmFlag <= 1'b0;
    end else begin
      if (regWrEn) ctrlReg <= regWrData;
      if (strobe.clrDiv) ctrlReg[BIT_DIV] <= 1'b0;
      if (strobe.clrWarm) warmFlag <= 1'b0;
      else if (strobe.setWarm) warmFlag <= 1'b1;
    end
  end

  assign regRdData = {warmFlag, ctrlReg};
  assign fastMode  = !ctrlReg[BIT_LONG];
  assign srcSel    = wakeSrc_t'(ctrlReg[4:2]);

  // output pins feed the neutral low value into the NOR groups
  assign p2Masked = p2Sync & ~p2DirOut;

  always_comb begin
    srcLevel = 1'b0;
    srcValid = 1'b1;
    unique case (srcSel)
      SRC_NONE, SRC_RSVD: srcValid = 1'b0;
      SRC_P31:  srcLevel = p3Sync[1];
      SRC_P32:  srcLevel = p3Sync[2];
      SRC_P33:  srcLevel = p3Sync[3];
      SRC_P27:  srcLevel = p2Sync[7];
      SRC_NORL: srcLevel = ~|p2Masked[3:0];
      SRC_NORA: srcLevel = ~|p2Masked;
    endcase
  end

  assign srcQual = (srcValid && (srcLevel == ctrlReg[BIT_LEVEL])) || auxSync;

  // clock enable divider
  assign divLimit = ctrlReg[BIT_DIV] ? DIV_W'(DIV_MAX - 1) : DIV_W'(DIV_BASE - 1);
  assign sysTick  = (divCnt >= divLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (sysTick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
endmodule

// File: rtl/swkControl.sv
module swkControl
  import swkPkg::*;
#(
  parameter int MIN_WIDTH  = 5,
  parameter int LONG_DELAY = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopEntry,
  input  logic       wdtTimeout,
  input  logic       srcQual,
  input  logic       fastMode,
  output swkStrobe_t strobe,
  output logic       wakeReq,
  output logic       coreRstHold,
  output logic       releaseDone,
  output logic       stopped
);
  localparam int WCNT_W = $clog2(MIN_WIDTH + 1);
  localparam int HOLD_W = $clog2(LONG_DELAY + 1);

  swkState_t         state;
  logic [WCNT_W-1:0] widthCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              widthMet, accept;

  assign widthMet = !fastMode || (widthCnt == WCNT_W'(MIN_WIDTH - 1));
  assign accept   = (state == ST_STOP) && (wdtTimeout || (srcQual && widthMet));

  always_comb begin
    strobe.setWarm = (state == ST_RUN) && stopEntry && !wdtTimeout;
    strobe.clrWarm = (state != ST_STOP) && wdtTimeout;
    strobe.clrDiv  = accept;
  end

  assign stopped     = (state == ST_STOP);
  assign coreRstHold = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_RUN;
      widthCnt    <= '0;
      holdCnt     <= '0;
      wakeReq     <= 1'b0;
      releaseDone <= 1'b0;
    end else begin
      wakeReq     <= accept;
      releaseDone <= 1'b0;
      unique case (state)
        ST_RUN: begin
          widthCnt <= '0;
          if (stopEntry && !wdtTimeout) state <= ST_STOP;
        end
        ST_STOP: begin
          if (accept) begin
            state    <= ST_HOLD;
            widthCnt <= '0;
            holdCnt  <= fastMode ? '0 : HOLD_W'(LONG_DELAY - 1);
          end else if (!srcQual) begin
            widthCnt <= '0;
          end else if (widthCnt != WCNT_W'(MIN_WIDTH - 1)) begin
            widthCnt <= widthCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (holdCnt == '0) begin
            state       <= ST_RUN;
            releaseDone <= 1'b1;
          end else begin
            holdCnt <= holdCnt - 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/stopWakeCtrl.sv
module stopWakeCtrl
  import swkPkg::*;
#(
  parameter int MIN_WIDTH  = 5,
  parameter int LONG_DELAY = 250000,
  parameter int DIV_BASE   = 2,
  parameter int DIV_EXTRA  = 16
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       stopEntry,
  input  logic       wdtTimeout,
  input  logic [7:0] p2Pins,
  input  logic [7:0] p2DirOut,
  input  logic [3:1] p3Pins,
  input  logic       auxWake,
  output logic       wakeReq,
  output logic       coreRstHold,
  output logic       releaseDone,
  output logic       stopped,
  output logic       sysTick
);
  swkStrobe_t strobe;
  logic       fastMode;
  logic       srcQual;
  logic       wrFlagUnused;

  assign wrFlagUnused = regWrData[7];

  swkDatapath #(
    .DIV_BASE (DIV_BASE),
    .DIV_EXTRA(DIV_EXTRA)
  ) i_datapath (
    .clk      (clk),
    .rstN     (porN),
    .regWrEn  (regWrEn),
    .regWrData(regWrData[6:0]),
    .strobe   (strobe),
    .p2Pins   (p2Pins),
    .p2DirOut (p2DirOut),
    .p3Pins   (p3Pins),
    .auxWake  (auxWake),
    .regRdData(regRdData),
    .fastMode (fastMode),
    .srcQual  (srcQual),
    .sysTick  (sysTick)
  );

  swkControl #(
    .MIN_WIDTH (MIN_WIDTH),
    .LONG_DELAY(LONG_DELAY)
  ) i_control (
    .clk        (clk),
    .rstN       (porN),
    .stopEntry  (stopEntry),
    .wdtTimeout (wdtTimeout),
    .srcQual    (srcQual),
    .fastMode   (fastMode),
    .strobe     (strobe),
    .wakeReq    (wakeReq),
    .coreRstHold(coreRstHold),
    .releaseDone(releaseDone),
    .stopped    (stopped)
  );
endmodule

// File: rtl/swkChecker.sv
module swkChecker (
  input logic       clk,
  input logic       porN,
  input logic [7:0] regRdData,
  input logic       wakeReq,
  input logic       coreRstHold,
  input logic       releaseDone,
  input logic       stopped
);
  AST_WAKE_STARTS_HOLD: assert property (@(posedge clk) disable iff (!porN)
    wakeReq |-> coreRstHold); // R7
  AST_WAKE_ONLY_FROM_STOP: assert property (@(posedge clk) disable iff (!porN)
    wakeReq |-> $past(stopped)); // R10
  AST_WARM_ON_STOP: assert property (@(posedge clk) disable iff (!porN)
    $rose(stopped) |-> regRdData[7]); // R2
  AST_DIV_CLEARED_ON_WAKE: assert property (@(posedge clk) disable iff (!porN)
    wakeReq |-> !regRdData[0]); // R11
  AST_DONE_ENDS_HOLD: assert property (@(posedge clk) disable iff (!porN)
    releaseDone |-> (!coreRstHold && $past(coreRstHold))); // R7
  AST_STOP_HOLD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!porN)
    !(stopped && coreRstHold)); // R7
endmodule

bind stopWakeCtrl swkChecker i_swkChecker (
  .clk        (clk),
  .porN       (porN),
  .regRdData  (regRdData),
  .wakeReq    (wakeReq),
  .coreRstHold(coreRstHold),
  .releaseDone(releaseDone),
  .stopped    (stopped)
);

// File: tb/test_stopWakeCtrl.sv
`timescale 1ns/1ps
module test_stopWakeCtrl;
  localparam int LONG = 20;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic stopEntry = 1'b0, wdtTimeout = 1'b0, auxWake = 1'b0;
  logic [7:0] p2Pins = '0, p2DirOut = '0;
  logic [3:1] p3Pins = '0;
  logic wakeReq, coreRstHold, releaseDone, stopped, sysTick;

  int total = 0, bad = 0;
  int wakeCnt = 0, doneCnt = 0, holdCyc = 0, tickCnt = 0;

  always #2 clk = ~clk;

  stopWakeCtrl #(.MIN_WIDTH(5), .LONG_DELAY(LONG)) i_stopWakeCtrl (
    .clk(clk), .porN(porN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .stopEntry(stopEntry), .wdtTimeout(wdtTimeout),
    .p2Pins(p2Pins), .p2DirOut(p2DirOut), .p3Pins(p3Pins), .auxWake(auxWake),
    .wakeReq(wakeReq), .coreRstHold(coreRstHold), .releaseDone(releaseDone),
    .stopped(stopped), .sysTick(sysTick)
  );

  always @(negedge clk) begin
    if (wakeReq) wakeCnt++;
    if (releaseDone) doneCnt++;
    if (coreRstHold) holdCyc++;
    if (sysTick) tickCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic enterStop();
    @(negedge clk); stopEntry = 1'b1;
    @(negedge clk); stopEntry = 1'b0;
  endtask

  task automatic kickWdt();
    @(negedge clk); wdtTimeout = 1'b1;
    @(negedge clk); wdtTimeout = 1'b0;
  endtask

  // one stop/wake attempt; cfg bits: 6 level, 5 long, 4:2 source, 0 divide
  task automatic runWake(input string req, input logic [7:0] cfg, input logic [7:0] dir,
                         input logic [7:0] idleP2, input logic [3:1] idleP3,
                         input logic [7:0] actP2, input logic [3:1] actP3,
                         input logic actAux, input int width, input bit expWake);
    int w0, d0;
    p2DirOut = dir; p2Pins = idleP2; p3Pins = idleP3; auxWake = 1'b0;
    writeReg(cfg);
    waitN(4);
    enterStop();
    waitN(2);
    chk(stopped === 1'b1, {req, " stopped"}, int'(stopped), 1);
    w0 = wakeCnt; d0 = doneCnt; holdCyc = 0;
    @(negedge clk); p2Pins = actP2; p3Pins = actP3; auxWake = actAux;
    waitN(width);
    p2Pins = idleP2; p3Pins = idleP3; auxWake = 1'b0;
    waitN(LONG + 12);
    chk(wakeCnt - w0 == int'(expWake), {req, " wake count"}, wakeCnt - w0, int'(expWake));
    if (expWake) begin
      chk(stopped === 1'b0, {req, " left stop"}, int'(stopped), 0);
      chk(holdCyc == (cfg[5] ? LONG : 1), {req, " hold length"}, holdCyc, cfg[5] ? LONG : 1);
      chk(doneCnt - d0 == 1, {req, " done pulse"}, doneCnt - d0, 1);
      chk(regRdData[7] === 1'b1, {req, " warm flag"}, int'(regRdData[7]), 1);
    end else begin
      chk(stopped === 1'b1, {req, " still stopped"}, int'(stopped), 1);
      kickWdt();
      waitN(LONG + 12);
    end
  endtask

  task automatic tReset();
    chk(regRdData === 8'h20, "R1 reset register", regRdData, 8'h20);
    chk(stopped === 1'b0 && coreRstHold === 1'b0, "R1 reset state", {stopped, coreRstHold}, 0);
    chk(wakeReq === 1'b0 && releaseDone === 1'b0, "R1 reset pulses", {wakeReq, releaseDone}, 0);
  endtask

  task automatic tFlagWrite();
    writeReg(8'hC4);
    waitN(1);
    chk(regRdData === 8'h44, "R2 bit7 write ignored", regRdData, 8'h44);
  endtask

  task automatic tSources();
    runWake("R3 src010", 8'h48, 8'h00, 8'h00, 3'b000, 8'h00, 3'b001, 1'b0, 8, 1'b1);
    runWake("R3 src010 other pin", 8'h48, 8'h00, 8'h00, 3'b000, 8'hFF, 3'b110, 1'b0, 8, 1'b0);
    runWake("R3 src011", 8'h4C, 8'h00, 8'h00, 3'b000, 8'h00, 3'b010, 1'b0, 8, 1'b1);
    runWake("R3 src100", 8'h50, 8'h00, 8'h00, 3'b000, 8'h00, 3'b100, 1'b0, 8, 1'b1);
    runWake("R3 src101", 8'h54, 8'h00, 8'h00, 3'b000, 8'h80, 3'b000, 1'b0, 8, 1'b1);
    runWake("R3 src110 nor low", 8'h58, 8'h00, 8'h01, 3'b000, 8'h10, 3'b000, 1'b0, 8, 1'b1);
    runWake("R3 src111 nor all", 8'h5C, 8'h00, 8'h01, 3'b000, 8'h10, 3'b000, 1'b0, 8, 1'b0);
  endtask

  task automatic tLevel();
    runWake("R4 level low", 8'h08, 8'h00, 8'h00, 3'b111, 8'h00, 3'b110, 1'b0, 8, 1'b1);
    runWake("R4 level low high pin", 8'h08, 8'h00, 8'h00, 3'b101, 8'h00, 3'b111, 1'b0, 8, 1'b0);
  endtask

  task automatic tMask();
    runWake("R5 output pin masked", 8'h5C, 8'h01, 8'h03, 3'b000, 8'h01, 3'b000, 1'b0, 8, 1'b1);
  endtask

  task automatic tWidth();
    runWake("R6 fast width 4", 8'h48, 8'h00, 8'h00, 3'b000, 8'h00, 3'b001, 1'b0, 4, 1'b0);
    runWake("R6 fast width 5", 8'h48, 8'h00, 8'h00, 3'b000, 8'h00, 3'b001, 1'b0, 5, 1'b1);
    runWake("R6 long width 1", 8'h68, 8'h00, 8'h00, 3'b000, 8'h00, 3'b001, 1'b0, 1, 1'b1);
  endtask

  task automatic tDelay();
    runWake("R7 long hold", 8'h68, 8'h00, 8'h00, 3'b000, 8'h00, 3'b001, 1'b0, 3, 1'b1);
    runWake("R7 fast hold", 8'h48, 8'h00, 8'h00, 3'b000, 8'h00, 3'b001, 1'b0, 8, 1'b1);
  endtask

  task automatic tAux();
    runWake("R8 aux source", 8'h40, 8'h00, 8'h00, 3'b000, 8'h00, 3'b000, 1'b1, 8, 1'b1);
  endtask

  task automatic tWatchdog();
    int w0;
    writeReg(8'h40);
    waitN(4);
    enterStop();
    waitN(2);
    w0 = wakeCnt; holdCyc = 0;
    kickWdt();
    waitN(6);
    chk(wakeCnt - w0 == 1, "R9 wdt in stop wakes", wakeCnt - w0, 1);
    chk(regRdData[7] === 1'b1, "R9 wdt in stop warm", int'(regRdData[7]), 1);
    chk(stopped === 1'b0, "R9 wdt in stop left", int'(stopped), 0);
    kickWdt();
    waitN(2);
    chk(regRdData === 8'h40, "R9 wdt running cold", regRdData, 8'h40);
  endtask

  task automatic tIgnored();
    int w0;
    writeReg(8'h48);
    w0 = wakeCnt;
    @(negedge clk); p3Pins = 3'b001;
    waitN(10);
    p3Pins = 3'b000;
    waitN(4);
    chk(wakeCnt == w0 && stopped === 1'b0, "R10 running pins ignored", wakeCnt - w0, 0);
    runWake("R10 src000 high", 8'h40, 8'h00, 8'h00, 3'b000, 8'hFF, 3'b111, 1'b0, 8, 1'b0);
    runWake("R10 src001 high", 8'h44, 8'h00, 8'h00, 3'b000, 8'hFF, 3'b111, 1'b0, 8, 1'b0);
    runWake("R10 src001 low", 8'h04, 8'h00, 8'hFF, 3'b111, 8'h00, 3'b000, 1'b0, 8, 1'b0);
  endtask

  task automatic tDivider();
    writeReg(8'h21);
    waitN(40);
    tickCnt = 0;
    waitN(64);
    chk(tickCnt == 2, "R11 divide by 32", tickCnt, 2);
    writeReg(8'h20);
    waitN(40);
    tickCnt = 0;
    waitN(64);
    chk(tickCnt == 32, "R11 divide by 2", tickCnt, 32);
    runWake("R11 wake divided", 8'h49, 8'h00, 8'h00, 3'b000, 8'h00, 3'b001, 1'b0, 8, 1'b1);
    chk(regRdData[0] === 1'b0, "R11 divide cleared", int'(regRdData[0]), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitN(3);
    tReset();
    porN = 1'b1;
    waitN(2);
    tFlagWrite();
    tSources();
    tLevel();
    tMask();
    tWidth();
    tDelay();
    tAux();
    tWatchdog();
    tIgnored();
    tDivider();
    waitN(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule